// File: doc/BRIEF.md
# External Interrupt Pin Controller

The controller watches a set of external interrupt pins split into equal banks (by default 32 pins in four banks of eight). Each pin is first brought into the clock domain through a synchronizer, then checked every cycle against its own trigger mode: low level, high level, falling edge, rising edge or both edges. A trigger event sets the pin's pending bit, which stays set until software clears it.

Every bank has three registers on a plain single-cycle register bus: trigger configuration, mask and pending. The bus has no back-pressure. A write strobe is taken on the clock edge it is sampled on, and read data is returned combinationally in the same cycle as the read strobe. The lower sixteen pins each drive their own interrupt line. The upper sixteen share one line, and software finds the source by reading the pending and mask registers of the upper banks.

Pin `p` lives in bank `p >> 3` at bit position `p % 8`.

Top module: `eirq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every mask register reads 0xFF, every configuration and pending register reads 0, and all interrupt outputs are low.
- R2: Bank `b` decodes at word address `4*b + s`, where `s` selects the register:
  - `s = 0`: configuration.
  - `s = 1`: mask.
  - `s = 2`: pending.
  - `s = 3`: reads 0.

  In the configuration word, pin `k` of the bank owns bits `[4k+2:4k]`. Bit `4k+3` always reads 0.
- R3: A mask bit of 1 masks its pin and a mask bit of 0 unmasks it. The written value reads back unchanged.
- R4: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. The bus cannot set a pending bit.
- R5: Mode code 3 (rising edge) sets pending on a synchronized 0-to-1 transition only.
- R6: Mode code 2 (falling edge) sets pending on a synchronized 1-to-0 transition only.
- R7: Mode code 4 (both edges) sets pending on either transition.
- R8: Mode codes 0 (low level) and 1 (high level) set pending on every cycle the level is active. A clear written while the level is still active has no effect.
- R9: Mode codes 5, 6 and 7 never set pending.
- R10: A pin change reaches the pending bit on the third rising clock edge after it, through two synchronizer flops. It is not visible after the second edge.
- R11: Pending bits latch events whether or not the pin is masked.
- R12: For each pin 0..15, `irq_direct[p]` is high exactly when that pin is pending and unmasked.
- R13: `irq_shared` is high exactly when at least one pin 16..31 is pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Asynchronous external interrupt pins |
| bus_addr | input | 4 | Register word address {bank, select} |
| bus_wr | input | 1 | Write strobe, taken on the clock edge |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read |
| irq_direct | output | 16 | Per-pin interrupt lines for pins 0..15 |
| irq_shared | output | 1 | Combined interrupt line for pins 16..31 |

## Verification
The assertions assume that the pending bits change only through trigger events or bus writes, and that reset is applied once before the block is used. The stimulus changes pins and bus strobes half a cycle away from the sampling edge, raises at most one strobe per cycle, and keeps each pin level for at least a full clock so that every edge passes the synchronizer. The behavioural model uses a three-deep history of pin samples rather than a flop chain. It predicts the pending, mask and configuration state, and so both the outputs and every read value.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  localparam int SLOT_W = 4;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  typedef enum logic [1:0] {
    RSEL_CFG  = 2'd0,
    RSEL_MASK = 2'd1,
    RSEL_PEND = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;

  // Decide whether one pin fires this cycle from its mode and two samples.
  function automatic logic trig_hit(input logic [MODE_W-1:0] mode,
                                    input logic cur, input logic prev);
    case (mode)
      TRIG_LOW:  return !cur;
      TRIG_HIGH: return cur;
      TRIG_FALL: return prev && !cur;
      TRIG_RISE: return !prev && cur;
      TRIG_BOTH: return prev != cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);

  logic [STAGES-1:0][WIDTH-1:0] stg;
  logic [WIDTH-1:0]             last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= '0;
      last <= '0;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      last <= stg[STAGES-1];
    end
  end

  assign cur  = stg[STAGES-1];
  assign prev = last;

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0][MODE_W-1:0] mode,
  input  logic [PINS-1:0]             cur,
  input  logic [PINS-1:0]             prev,
  output logic [PINS-1:0]             hit
);

  for (genvar k = 0; k < PINS; k++) begin : g_pin
    assign hit[k] = trig_hit(mode[k], cur[k], prev[k]);
  end

endmodule

// File: rtl/eirq_bank.sv
module eirq_bank
  import eirq_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  rsel_e             sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PINS-1:0]   cur,
  input  logic [PINS-1:0]   prev,
  output logic [DATA_W-1:0] cfg_word,
  output logic [PINS-1:0]   mask_q,
  output logic [PINS-1:0]   pend_q
);

  localparam int CFG_USED = PINS * SLOT_W;

  logic [PINS-1:0][MODE_W-1:0] mode_q;
  logic [PINS-1:0]             hit;
  logic [PINS-1:0]             clr;
  logic                        unused_wbits;

  eirq_detect #(.PINS(PINS)) u_detect (
    .mode (mode_q),
    .cur  (cur),
    .prev (prev),
    .hit  (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_en && sel == RSEL_CFG) begin
      for (int k = 0; k < PINS; k++) mode_q[k] <= wdata[k*SLOT_W +: MODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_en && sel == RSEL_MASK) begin
      mask_q <= wdata[PINS-1:0];
    end
  end

  assign clr = (wr_en && sel == RSEL_PEND) ? wdata[PINS-1:0] : '0;

  // A trigger event in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | hit;
  end

  for (genvar k = 0; k < PINS; k++) begin : g_slot
    assign cfg_word[k*SLOT_W +: SLOT_W] = {{(SLOT_W-MODE_W){1'b0}}, mode_q[k]};
  end
  if (DATA_W > CFG_USED) begin : g_pad
    assign cfg_word[DATA_W-1:CFG_USED] = '0;
  end

  assign unused_wbits = ^wdata;

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int  NUM_BANKS   = 4,
  parameter int  BANK_PINS   = 8,
  parameter int  DIRECT_PINS = 16,
  parameter int  SYNC_STAGES = 2,
  parameter int  DATA_W      = 32,
  localparam int NUM_PINS    = NUM_BANKS * BANK_PINS,
  localparam int BANK_AW     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W      = BANK_AW + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PINS-1:0]    pin_in,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [DIRECT_PINS-1:0] irq_direct,
  output logic                   irq_shared
);

  localparam int SHARED_PINS = NUM_PINS - DIRECT_PINS;

  logic [NUM_PINS-1:0]               pin_cur;
  logic [NUM_PINS-1:0]               pin_prev;
  logic [NUM_PINS-1:0]               pend_all;
  logic [NUM_PINS-1:0]               mask_all;
  logic [NUM_BANKS-1:0][DATA_W-1:0]  cfg_words;
  logic [BANK_AW-1:0]                bank_idx;
  rsel_e                             sel;

  assign bank_idx = bus_addr[ADDR_W-1:2];
  assign sel      = rsel_e'(bus_addr[1:0]);

  eirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pin_in),
    .cur  (pin_cur),
    .prev (pin_prev)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_here;
    assign wr_here = bus_wr && (bank_idx == BANK_AW'(b));

    eirq_bank #(.PINS(BANK_PINS), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_here),
      .sel     (sel),
      .wdata   (bus_wdata),
      .cur     (pin_cur[b*BANK_PINS +: BANK_PINS]),
      .prev    (pin_prev[b*BANK_PINS +: BANK_PINS]),
      .cfg_word(cfg_words[b]),
      .mask_q  (mask_all[b*BANK_PINS +: BANK_PINS]),
      .pend_q  (pend_all[b*BANK_PINS +: BANK_PINS])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        RSEL_CFG:  bus_rdata = cfg_words[bank_idx];
        RSEL_MASK: bus_rdata = DATA_W'(mask_all[int'(bank_idx)*BANK_PINS +: BANK_PINS]);
        RSEL_PEND: bus_rdata = DATA_W'(pend_all[int'(bank_idx)*BANK_PINS +: BANK_PINS]);
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq_direct = pend_all[DIRECT_PINS-1:0] & ~mask_all[DIRECT_PINS-1:0];
  assign irq_shared = |(pend_all[NUM_PINS-1 -: SHARED_PINS] & ~mask_all[NUM_PINS-1 -: SHARED_PINS]);

endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk #(
  parameter int NUM_PINS    = 32,
  parameter int DIRECT_PINS = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [1:0]             bus_sel,
  input logic [DIRECT_PINS-1:0] irq_direct,
  input logic                   irq_shared,
  input logic [NUM_PINS-1:0]    pend,
  input logic [NUM_PINS-1:0]    mask
);

  localparam int UP = NUM_PINS - DIRECT_PINS;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_direct == '0 && !irq_shared)); // R1
  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == '1)); // R1
  AST_PEND_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend) & ~pend)) |-> ($past(bus_wr) && $past(bus_sel) == 2'd2)); // R4
  AST_DIRECT_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_direct & mask[DIRECT_PINS-1:0]) == '0); // R12
  AST_DIRECT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_direct & ~pend[DIRECT_PINS-1:0]) == '0); // R12
  AST_SHARED_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared |-> (|pend[NUM_PINS-1 -: UP])); // R13
  AST_SHARED_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask[NUM_PINS-1 -: UP]) |-> !irq_shared); // R13

endmodule

bind eirq_ctrl eirq_ctrl_chk #(.NUM_PINS(NUM_PINS), .DIRECT_PINS(DIRECT_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_sel   (bus_addr[1:0]),
  .irq_direct(irq_direct),
  .irq_shared(irq_shared),
  .pend      (pend_all),
  .mask      (mask_all)
);

// File: tb/tb_eirq_ctrl.sv
module tb_eirq_ctrl;

  localparam int NP = 32;
  localparam int DP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [DP-1:0] irq_direct;
  logic          irq_shared;

  always #5 clk = ~clk;

  eirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_direct(irq_direct), .irq_shared(irq_shared)
  );

  int checks = 0;
  int failures = 0;

  // Behavioural reference model
  bit [NP-1:0] m_mask = '1;
  bit [NP-1:0] m_pend = '0;
  bit [2:0]    m_mode [NP];
  bit [NP-1:0] hist [$] = '{32'h0, 32'h0, 32'h0};

  function automatic bit m_fire(int mode, bit c, bit p);
    case (mode)
      0: return !c;
      1: return c;
      2: return p && !c;
      3: return !p && c;
      4: return p != c;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit [NP-1:0] c, p, fire, clr;
    int bk;
    if (!rst_n) begin
      m_mask = '1;
      m_pend = '0;
      foreach (m_mode[i]) m_mode[i] = 3'd0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      c = hist[1];
      p = hist[2];
      for (int i = 0; i < NP; i++) fire[i] = m_fire(int'(m_mode[i]), c[i], p[i]);
      clr = '0;
      bk = int'(bus_addr[3:2]);
      if (bus_wr) begin
        case (bus_addr[1:0])
          2'd0: for (int k = 0; k < 8; k++) m_mode[bk*8+k] = bus_wdata[4*k +: 3];
          2'd1: m_mask[bk*8 +: 8] = bus_wdata[7:0];
          2'd2: clr[bk*8 +: 8] = bus_wdata[7:0];
          default: ;
        endcase
      end
      m_pend = (m_pend & ~clr) | fire;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(logic [3:0] a);
    int bk = int'(a[3:2]);
    logic [31:0] r = '0;
    case (a[1:0])
      2'd0: for (int k = 0; k < 8; k++) r[4*k +: 4] = {1'b0, m_mode[bk*8+k]};
      2'd1: r = {24'h0, m_mask[bk*8 +: 8]};
      2'd2: r = {24'h0, m_pend[bk*8 +: 8]};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Every clock: outputs against the model (R12, R13)
  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      expect_eq("R12", "irq_direct vs model", 32'(irq_direct), 32'(m_pend[15:0] & ~m_mask[15:0]));
      expect_eq("R13", "irq_shared vs model", 32'(irq_shared), 32'(|(m_pend[31:16] & ~m_mask[31:16])));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    expect_eq(req, $sformatf("read addr %0d", a), bus_rdata, exp);
    expect_eq(req, $sformatf("read addr %0d vs model", a), bus_rdata, m_read(a));
    bus_rd = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      rd(4'(b*4+1), 32'hFF, "R1");
      rd(4'(b*4), 32'h0, "R1");
      rd(4'(b*4+2), 32'h0, "R1");
    end
    expect_eq("R1", "irq_direct in reset", 32'(irq_direct), 32'h0);
    expect_eq("R1", "irq_shared in reset", 32'(irq_shared), 32'h0);
    rst_n = 1'b1;
    wait_n(2);
    for (int b = 0; b < 4; b++) wr(4'(b*4), 32'h33333333);
    for (int b = 0; b < 4; b++) wr(4'(b*4+2), 32'hFF);
    for (int b = 0; b < 4; b++) rd(4'(b*4+2), 32'h0, "R4");

    // R2 map and field packing
    wr(4'd0, 32'hFFFFFFFF);
    rd(4'd0, 32'h77777777, "R2");
    rd(4'd3, 32'h0, "R2");
    wr(4'd0, 32'h33333333);
    rd(4'd0, 32'h33333333, "R2");

    // R3 mask write and read back
    wr(4'd1, 32'h0F); rd(4'd1, 32'h0F, "R3");
    wr(4'd1, 32'h00); rd(4'd1, 32'h00, "R3");

    // R10 latency and R5 rising edge
    pin_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    expect_eq("R10", "not yet pending after two edges", 32'(irq_direct), 32'h0);
    @(negedge clk);
    expect_eq("R10", "pending on third edge", 32'(irq_direct), 32'h0004);
    rd(4'd2, 32'h04, "R5");
    pin_in[2] = 1'b0; wait_n(5);
    rd(4'd2, 32'h04, "R5");
    wr(4'd2, 32'h00); rd(4'd2, 32'h04, "R4");
    wr(4'd2, 32'h04); rd(4'd2, 32'h00, "R4");
    expect_eq("R4", "irq cleared", 32'(irq_direct), 32'h0);

    // R11 masked pin still latches, R12 mask gates output
    wr(4'd1, 32'h04);
    pin_in[2] = 1'b1; wait_n(5);
    rd(4'd2, 32'h04, "R11");
    expect_eq("R12", "masked direct low", 32'(irq_direct), 32'h0);
    wr(4'd1, 32'h00);
    expect_eq("R12", "unmasked direct high", 32'(irq_direct), 32'h0004);
    pin_in[2] = 1'b0; wait_n(5);
    wr(4'd2, 32'h04); rd(4'd2, 32'h0, "R4");

    // R6 falling edge
    wr(4'd4, 32'h22222222); wr(4'd5, 32'h0);
    pin_in[9] = 1'b1; wait_n(5);
    rd(4'd6, 32'h0, "R6");
    pin_in[9] = 1'b0; wait_n(5);
    rd(4'd6, 32'h02, "R6");
    expect_eq("R12", "pin 9 line", 32'(irq_direct), 32'h0200);
    wr(4'd6, 32'h02); rd(4'd6, 32'h0, "R4");

    // R7 both edges
    wr(4'd8, 32'h44444444); wr(4'd9, 32'h0);
    pin_in[17] = 1'b1; wait_n(5);
    rd(4'd10, 32'h02, "R7");
    expect_eq("R13", "shared high", 32'(irq_shared), 32'h1);
    wr(4'd10, 32'h02);
    expect_eq("R13", "shared low after clear", 32'(irq_shared), 32'h0);
    pin_in[17] = 1'b0; wait_n(5);
    rd(4'd10, 32'h02, "R7");
    wr(4'd10, 32'h02); rd(4'd10, 32'h0, "R7");

    // R9 reserved codes
    wr(4'd4, 32'h76576576);
    pin_in[15:8] = 8'hFF; wait_n(5);
    pin_in[15:8] = 8'h00; wait_n(5);
    rd(4'd6, 32'h0, "R9");
    expect_eq("R9", "no direct lines", 32'(irq_direct), 32'h0);

    // R8 high level, clear ignored while active
    wr(4'd12, 32'h11111111); wr(4'd13, 32'h0);
    pin_in[30] = 1'b1; wait_n(5);
    rd(4'd14, 32'h40, "R8");
    wr(4'd14, 32'h40); rd(4'd14, 32'h40, "R8");
    expect_eq("R8", "shared held by level", 32'(irq_shared), 32'h1);
    pin_in[30] = 1'b0; wait_n(5);
    rd(4'd14, 32'h40, "R8");
    wr(4'd14, 32'h40); rd(4'd14, 32'h0, "R8");
    expect_eq("R13", "shared low", 32'(irq_shared), 32'h0);

    // R8 low level
    wr(4'd12, 32'h11110111); wait_n(5);
    rd(4'd14, 32'h08, "R8");
    pin_in[27] = 1'b1; wait_n(5);
    wr(4'd12, 32'h11111111);
    pin_in[27] = 1'b0; wait_n(5);
    wr(4'd14, 32'hFF); rd(4'd14, 32'h0, "R8");

    // R11 on the shared line
    wr(4'd9, 32'hFF);
    pin_in[20] = 1'b1; wait_n(5);
    rd(4'd10, 32'h10, "R11");
    expect_eq("R11", "shared masked low", 32'(irq_shared), 32'h0);
    wr(4'd9, 32'hEF);
    expect_eq("R13", "shared after unmask", 32'(irq_shared), 32'h1);
    pin_in[20] = 1'b0; wait_n(5);
    wr(4'd10, 32'h10); rd(4'd10, 32'h0, "R4");
    wr(4'd9, 32'h00);

    // Mixed traffic against the model
    for (int it = 0; it < 800; it++) begin
      logic [3:0] a;
      pin_in = pin_in ^ ($urandom & $urandom & $urandom);
      if (($urandom % 4) == 0) wr(4'($urandom), $urandom);
      else @(negedge clk);
      a = 4'($urandom);
      rd(a, m_read(a), "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule